// File: doc/BRIEF.md
# Variable-Length Instruction Splitter

This block takes a ten-byte window of instruction memory, with byte 0 at the current program counter, and splits one instruction of a compact 64-bit register/memory/stack instruction set into its fields. It returns the operation class and the variant selector, the two register identifiers, an eight-byte constant, the address of the following instruction, and two flags that say whether a register byte and a constant were found. It also reports a status: normal, stopped, or illegal.

The instruction length is worked out from byte 0 alone. Byte 0 is always present. A register byte and an eight-byte constant follow it when the format calls for them. The constant sits in byte 1 onward when no register byte is present, and in byte 2 onward when one is. Fetching the window from memory, the register file and execution all belong to neighbouring blocks. The decode logic is combinational. It feeds one output register stage, selected by the `REG_OUT` parameter (default 1). With that stage in place, every result appears one clock after its window and PC are presented.

Top module: `vl_fetch_split`

## Requirements
- R1: While `rst_n` is low, the outputs are as follows. `status` is 0, meaning no result yet. `ra` and `rb` are 0xF. `icode`, `ifun`, `valc` and `valp` are 0. `need_reg` and `need_const` are 0.
- R2: `icode` is the high nibble of byte 0 (`win[7:4]`) and `ifun` is its low nibble (`win[3:0]`). Both appear one clock after the window is presented.
- R3: The length depends on `icode`. Codes 0x0 (stop), 0x1 (idle) and 0x9 (return) are 1 byte. Codes 0x2 (conditional register move), 0x6 (ALU), 0xA (push) and 0xB (pop) are 2 bytes. Codes 0x7 (branch) and 0x8 (call) are 9 bytes. Codes 0x3 (immediate load), 0x4 (store) and 0x5 (load) are 10 bytes.
- R4: `valp` equals `pc` plus the length, computed modulo 2^64, so an address near the top wraps around to zero.
- R5: For 2-byte and 10-byte forms, `need_reg` is 1. `ra` is the high nibble of byte 1 (`win[15:12]`) and `rb` is its low nibble (`win[11:8]`).
- R6: For every other form, `need_reg` is 0 and both `ra` and `rb` are 0xF, the "no register" ID.
- R7: For 10-byte forms, `valc` is bytes 2..9 (`win[79:16]`), least significant byte first. For 9-byte forms, `valc` is bytes 1..8 (`win[71:8]`). In both cases `need_const` is 1.
- R8: For 1-byte and 2-byte forms, `need_const` is 0 and `valc` is 0.
- R9: `status` is 1 for a legal instruction. It is 2 when byte 0 is 0x00 (stop), so running into zeroed memory halts. It is 4 for an illegal instruction.
- R10: An instruction is illegal in any of these cases: `icode` is above 0xB; `icode` is 0x6 and `ifun` is above 3; `icode` is 0x2 or 0x7 and `ifun` is above 6; any other code has a nonzero `ifun`.
- R11: An illegal instruction is treated as 1 byte long. Both flags are 0, `ra` and `rb` are 0xF, and `valc` is 0.

Ports table follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| win | input | 80 | Instruction window; byte k sits in bits 8k+7..8k |
| pc | input | 64 | Address of byte 0 of the window |
| icode | output | 4 | Operation class |
| ifun | output | 4 | Variant selector |
| ra | output | 4 | First register ID, 0xF if absent |
| rb | output | 4 | Second register ID, 0xF if absent |
| valc | output | 64 | Constant or destination, 0 if absent |
| valp | output | 64 | Address of the next sequential instruction |
| need_reg | output | 1 | A register byte was decoded |
| need_const | output | 1 | A constant was decoded |
| status | output | 3 | 0 none, 1 normal, 2 stopped, 4 illegal |

## Verification
With the default output stage, every result (fields, flags, `valp` and `status`) is due exactly one rising edge after its window and PC are applied. The reset values hold for as long as `rst_n` is low. The bench changes the inputs on a falling edge, lets one rising edge capture them, and reads the outputs on the next falling edge, before the following vector is applied. The reset values are read while reset is still held. The assertions check the same one-edge delay by comparing outputs against the inputs sampled at the previous edge.

// File: rtl/vlf_pkg.sv
package vlf_pkg;

  typedef enum logic [3:0] {
    OP_STOP   = 4'h0,
    OP_IDLE   = 4'h1,
    OP_RMOVE  = 4'h2,
    OP_IMOVE  = 4'h3,
    OP_STORE  = 4'h4,
    OP_LOAD   = 4'h5,
    OP_ALU    = 4'h6,
    OP_BRANCH = 4'h7,
    OP_CALL   = 4'h8,
    OP_RETURN = 4'h9,
    OP_PUSH   = 4'hA,
    OP_POP    = 4'hB
  } op_e;

  typedef enum logic [2:0] {
    ST_NONE = 3'd0,
    ST_RUN  = 3'd1,
    ST_STOP = 3'd2,
    ST_BAD  = 3'd4
  } stat_e;

  localparam logic [3:0] NO_REG = 4'hF;

  // Legality of a class / variant pair.
  function automatic logic fn_legal(logic [3:0] ic, logic [3:0] fn);
    unique case (ic)
      OP_ALU:                fn_legal = (fn <= 4'd3);
      OP_RMOVE, OP_BRANCH:   fn_legal = (fn <= 4'd6);
      OP_STOP, OP_IDLE, OP_IMOVE, OP_STORE, OP_LOAD,
      OP_CALL, OP_RETURN, OP_PUSH, OP_POP:
                             fn_legal = (fn == 4'd0);
      default:               fn_legal = 1'b0;
    endcase
  endfunction

  // Length in bytes; illegal instructions count as one byte.
  function automatic logic [3:0] inst_len(logic [3:0] ic, logic ok);
    if (!ok) begin
      inst_len = 4'd1;
    end else begin
      unique case (ic)
        OP_RMOVE, OP_ALU, OP_PUSH, OP_POP: inst_len = 4'd2;
        OP_BRANCH, OP_CALL:                inst_len = 4'd9;
        OP_IMOVE, OP_STORE, OP_LOAD:       inst_len = 4'd10;
        default:                           inst_len = 4'd1;
      endcase
    end
  endfunction

  // Next sequential address, wrapping at the address width.
  function automatic logic [63:0] next_addr(logic [63:0] a, logic [3:0] n);
    next_addr = a + {60'd0, n};
  endfunction

endpackage

// File: rtl/vlf_class.sv
module vlf_class
  import vlf_pkg::*;
(
  input  logic [7:0] b0,
  output logic [3:0] icode,
  output logic [3:0] ifun,
  output logic       legal,
  output logic       is_stop,
  output logic       need_reg,
  output logic       need_const,
  output logic [3:0] len
);
  assign icode      = b0[7:4];
  assign ifun       = b0[3:0];
  assign legal      = fn_legal(icode, ifun);
  assign is_stop    = legal && (icode == OP_STOP);
  assign len        = inst_len(icode, legal);
  assign need_reg   = (len == 4'd2) || (len == 4'd10);
  assign need_const = (len == 4'd9) || (len == 4'd10);
endmodule

// File: rtl/vlf_field.sv
module vlf_field
  import vlf_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int CBYTES = XLEN / 8,
  localparam int TAIL_W = (CBYTES + 1) * 8
) (
  input  logic [TAIL_W-1:0] tail,
  input  logic              need_reg,
  input  logic              need_const,
  output logic [3:0]        ra,
  output logic [3:0]        rb,
  output logic [XLEN-1:0]   valc
);
  logic [XLEN-1:0] raw_const;

  // Constant byte k comes from tail byte k+1 with a register byte, else byte k.
  for (genvar k = 0; k < CBYTES; k++) begin : g_cbyte
    assign raw_const[8*k +: 8] = need_reg ? tail[8*(k+1) +: 8] : tail[8*k +: 8];
  end

  assign ra   = need_reg ? tail[7:4] : NO_REG;
  assign rb   = need_reg ? tail[3:0] : NO_REG;
  assign valc = need_const ? raw_const : '0;
endmodule

// File: rtl/vlf_nextpc.sv
module vlf_nextpc
  import vlf_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] pc,
  input  logic [3:0]      len,
  output logic [XLEN-1:0] valp
);
  assign valp = next_addr(pc, len);
endmodule

// File: rtl/vl_fetch_split.sv
module vl_fetch_split
  import vlf_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit REG_OUT = 1'b1,
  localparam int WIN_W  = (XLEN / 8 + 2) * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIN_W-1:0]  win,
  input  logic [XLEN-1:0]   pc,
  output logic [3:0]        icode,
  output logic [3:0]        ifun,
  output logic [3:0]        ra,
  output logic [3:0]        rb,
  output logic [XLEN-1:0]   valc,
  output logic [XLEN-1:0]   valp,
  output logic              need_reg,
  output logic              need_const,
  output logic [2:0]        status
);
  // Named internal events
  logic [3:0]      d_icode, d_ifun, d_ra, d_rb, d_len;
  logic            d_legal, d_stop, d_need_reg, d_need_const;
  logic [XLEN-1:0] d_valc, d_valp;
  stat_e           d_status;

  vlf_class u_class (
    .b0         (win[7:0]),
    .icode      (d_icode),
    .ifun       (d_ifun),
    .legal      (d_legal),
    .is_stop    (d_stop),
    .need_reg   (d_need_reg),
    .need_const (d_need_const),
    .len        (d_len)
  );

  vlf_field #(.XLEN(XLEN)) u_field (
    .tail       (win[WIN_W-1:8]),
    .need_reg   (d_need_reg),
    .need_const (d_need_const),
    .ra         (d_ra),
    .rb         (d_rb),
    .valc       (d_valc)
  );

  vlf_nextpc #(.XLEN(XLEN)) u_nextpc (
    .pc   (pc),
    .len  (d_len),
    .valp (d_valp)
  );

  assign d_status = !d_legal ? ST_BAD : (d_stop ? ST_STOP : ST_RUN);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        icode      <= '0;
        ifun       <= '0;
        ra         <= NO_REG;
        rb         <= NO_REG;
        valc       <= '0;
        valp       <= '0;
        need_reg   <= 1'b0;
        need_const <= 1'b0;
        status     <= ST_NONE;
      end else begin
        icode      <= d_icode;
        ifun       <= d_ifun;
        ra         <= d_ra;
        rb         <= d_rb;
        valc       <= d_valc;
        valp       <= d_valp;
        need_reg   <= d_need_reg;
        need_const <= d_need_const;
        status     <= d_status;
      end
    end
  end else begin : g_comb
    assign icode      = d_icode;
    assign ifun       = d_ifun;
    assign ra         = d_ra;
    assign rb         = d_rb;
    assign valc       = d_valc;
    assign valp       = d_valp;
    assign need_reg   = d_need_reg;
    assign need_const = d_need_const;
    assign status     = d_status;
  end
endmodule

// File: rtl/vlf_chk.sv
module vlf_chk #(
  parameter int XLEN    = 64,
  parameter bit REG_OUT = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      b0,
  input logic [XLEN-1:0] pc,
  input logic [3:0]      icode,
  input logic [3:0]      ra,
  input logic [3:0]      rb,
  input logic [XLEN-1:0] valc,
  input logic [XLEN-1:0] valp,
  input logic            need_reg,
  input logic            need_const,
  input logic [2:0]      status
);
  // R6
  no_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !need_reg |-> (ra == 4'hF && rb == 4'hF));

  // R8
  no_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !need_const |-> valc == '0);

  // R9
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status));

  if (REG_OUT) begin : g_timed
    // R2
    icode_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status != 3'd0 |-> icode == $past(b0[7:4]));

    // R9
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status != 3'd0 && $past(b0) == 8'h00) |->
        (status == 3'd2 && valp == $past(pc) + 1));

    // R11
    bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status == 3'd4 |-> (valp == $past(pc) + 1 && !need_reg && !need_const));
  end
endmodule

bind vl_fetch_split vlf_chk #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .b0         (win[7:0]),
  .pc         (pc),
  .icode      (icode),
  .ra         (ra),
  .rb         (rb),
  .valc       (valc),
  .valp       (valp),
  .need_reg   (need_reg),
  .need_const (need_const),
  .status     (status)
);

// File: tb/vl_fetch_split_test.sv
module vl_fetch_split_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [79:0] win = '0;
  logic [63:0] pc = '0;
  logic [3:0]  icode, ifun, ra, rb;
  logic [63:0] valc, valp;
  logic        need_reg, need_const;
  logic [2:0]  status;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  vl_fetch_split uut (
    .clk(clk), .rst_n(rst_n), .win(win), .pc(pc),
    .icode(icode), .ifun(ifun), .ra(ra), .rb(rb),
    .valc(valc), .valp(valp), .need_reg(need_reg),
    .need_const(need_const), .status(status)
  );

  function automatic bit b_ok(logic [7:0] b);
    case (b[7:4])
      4'h6:       return b[3:0] < 4;
      4'h2, 4'h7: return b[3:0] < 7;
      4'h0, 4'h1, 4'h3, 4'h4, 4'h5, 4'h8, 4'h9, 4'hA, 4'hB:
                  return b[3:0] == 0;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic int b_len(logic [7:0] b);
    if (!b_ok(b)) return 1;
    case (b[7:4])
      4'h3, 4'h4, 4'h5:       return 10;
      4'h7, 4'h8:             return 9;
      4'h2, 4'h6, 4'hA, 4'hB: return 2;
      default:                return 1;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic apply(logic [79:0] w, logic [63:0] a);
    int          n;
    bit          ok;
    logic [63:0] ec;
    @(negedge clk);
    win = w;
    pc  = a;
    @(negedge clk);
    n  = b_len(w[7:0]);
    ok = b_ok(w[7:0]);
    ec = (n == 10) ? w[79:16] : (n == 9) ? w[71:8] : 64'd0;
    chk("R2 icode/ifun", {56'd0, icode, ifun}, {56'd0, w[7:0]});
    chk("R3 R4 valp", valp, a + 64'(n));
    if (n == 2 || n == 10)
      chk("R5 regs", {59'd0, need_reg, ra, rb}, {59'd0, 1'b1, w[15:8]});
    else
      chk(ok ? "R6 regs" : "R11 regs", {59'd0, need_reg, ra, rb}, {59'd0, 1'b0, 8'hFF});
    if (n >= 9)
      chk("R7 const", valc, ec);
    else
      chk(ok ? "R8 const" : "R11 const", {63'd0, need_const} | valc, 64'd0);
    chk(ok ? "R9 status" : "R10 status", {61'd0, status},
        !ok ? 64'd4 : (w[7:0] == 8'h00) ? 64'd2 : 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    win = {80{1'b1}};
    pc  = 64'h1234;
    repeat (2) @(negedge clk);
    // R1 reset state, sampled while reset is held
    chk("R1 status", {61'd0, status}, 64'd0);
    chk("R1 regs", {56'd0, ra, rb}, 64'hFF);
    chk("R1 const/next", valc | valp, 64'd0);
    chk("R1 codes/flags", {54'd0, icode, ifun, need_reg, need_const}, 64'd0);
    rst_n = 1'b1;

    // directed corner cases
    apply(80'd0, 64'h100);                                   // R9 zero byte stops
    apply({64'h0000_0000_0000_ABCD, 8'hF3, 8'h30}, 64'h0);   // R7 immediate load
    apply({64'h1122_3344_5566_7788, 8'h45, 8'h50}, 64'hFFFF_FFFF_FFFF_FFFC); // R4 wrap
    apply({8'hEE, 64'hDEAD_BEEF_0000_0088, 8'h73}, 64'h40);  // R7 branch, 9 bytes
    apply({56'hFF, 8'h9C, 8'h80}, 64'h20);                   // call
    apply({72'h77, 8'h63}, 64'h10);                          // ALU fn 3 legal
    apply({72'h77, 8'h64}, 64'h10);                          // R10 ALU fn 4 illegal
    apply({72'h12, 8'h26}, 64'h10);                          // fn 6 legal
    apply({72'h12, 8'h77}, 64'h10);                          // R10 fn 7 illegal
    apply({72'h0F, 8'hA0}, 64'h8);                           // push
    apply({72'h3F, 8'hB0}, 64'h8);                           // pop
    apply({72'h55, 8'h90}, 64'hFFFF_FFFF_FFFF_FFFF);         // R6 return, wrap
    apply({72'h55, 8'h01}, 64'h4);                           // R10 stop with fn 1
    apply({72'h55, 8'h15}, 64'h4);                           // R10 idle with fn 5
    apply({72'h55, 8'hC0}, 64'h4);                           // R11 code above 0xB
    apply({72'h55, 8'hF6}, 64'h4);

    for (int i = 0; i < 300; i++) begin
      logic [79:0] w;
      logic [63:0] a;
      w = {$urandom(), $urandom(), $urandom()};
      a = {$urandom(), $urandom()};
      if (($urandom() % 4) != 0)
        w[7:0] = {4'($urandom() % 12), 4'($urandom() % 7)};
      apply(w, a);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule